// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs signed and unsigned integer multiplication and division over several clock cycles, one bit per cycle. An operation begins with a single-cycle start strobe that carries the operation code and two operands. A multiply writes its double-width product into a pair of result registers, HI and LO. A divide writes the quotient into LO and the remainder into HI. A busy flag covers the iterations, and a one-cycle done strobe marks the cycle in which the new HI and LO values appear.

Multiplication shifts and conditionally adds the multiplicand. Division uses restoring trial subtraction and produces one quotient bit per step. Signed operations run the same unsigned datapath on operand magnitudes and fix the signs of the results afterwards. The unit never reports overflow or a zero divisor. Instead, a status flag tells the consumer whether the last result fits in a single word. A zero divisor still takes the normal latency and gives a fixed result.

Top module: `muldiv_hilo`

## Requirements
- R1: While reset is asserted, and until the first operation completes, busy and done are 0, hi and lo are 0, and prod_fits is 1.
- R2: `op` is decoded as follows: bit 1 selects divide (1) or multiply (0), and bit 0 selects unsigned (1) or signed (0). The codes are 00 signed multiply, 01 unsigned multiply, 10 signed divide and 11 unsigned divide. A start is accepted only when busy is low.
- R3: busy rises in the cycle after an accepted start and stays high for exactly WIDTH cycles. done is high for exactly one cycle, namely the first cycle in which busy is low again.
- R4: hi and lo change only in the cycle where done is high.
- R5: A start that arrives while busy is high has no effect. The running operation keeps its operands, its latency and its result.
- R6: An unsigned multiply leaves the 2*WIDTH-bit product in {hi, lo}.
- R7: A signed multiply leaves the two's-complement 2*WIDTH-bit product in {hi, lo}.
- R8: An unsigned divide by a non-zero divisor leaves the quotient in lo and the remainder in hi.
- R9: A signed divide by a non-zero divisor truncates toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives lo equal to the most negative value and hi equal to 0.
- R10: A divide by zero, signed or unsigned, takes the normal latency and leaves lo with all bits set and hi equal to the dividend.
- R11: If the last completed operation was signed, prod_fits is 1 exactly when every bit of hi equals the top bit of lo. If it was unsigned, prod_fits is 1 exactly when hi is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code, sampled with start |
| opnd_a | input | WIDTH | Multiplicand or dividend |
| opnd_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle strobe marking new hi/lo values |
| hi | output | WIDTH | Upper product word or remainder |
| lo | output | WIDTH | Lower product word or quotient |
| prod_fits | output | 1 | Last result fits in one word, by its signedness |

## Verification
The checker captures op and both operands only in the cycle where start is accepted. Its model and divide-by-zero properties therefore assume those inputs are valid in that one cycle and need not be held afterwards. It also assumes start is a single-cycle strobe issued from a reset state. The bench raises start for exactly one cycle per operation, always while the unit is idle. The one exception is a deliberate strobe during busy, which exercises the ignore rule. The bench sweeps every operand pair and every operation code of a 4-bit instance and compares each result against plain integer arithmetic.

// File: rtl/md_pkg.sv
`timescale 1ns/1ps
package md_pkg;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  function automatic logic op_is_div(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] code);
    return ~code[0];
  endfunction

endpackage

// File: rtl/md_magnitude.sv
`timescale 1ns/1ps
module md_magnitude #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  input  logic             signed_en,
  output logic [WIDTH-1:0] mag,
  output logic             neg
);
  assign neg = signed_en & value[WIDTH-1];
  assign mag = neg ? (~value + 1'b1) : value;
endmodule

// File: rtl/md_step.sv
`timescale 1ns/1ps
module md_step #(
  parameter int WIDTH = 32
) (
  input  logic             is_div,
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] quo,
  input  logic [WIDTH-1:0] opnd,
  output logic [WIDTH:0]   acc_nx,
  output logic [WIDTH-1:0] quo_nx
);
  localparam int W = WIDTH;

  // one shift-and-add step: {acc, quo} shifts right, adding opnd when the multiplier bit is set
  function automatic logic [2*W:0] mul_step(input logic [W:0] a, input logic [W-1:0] q,
                                            input logic [W-1:0] m);
    logic [W:0] s;
    s = q[0] ? (a + {1'b0, m}) : a;
    return {1'b0, s, q[W-1:1]};
  endfunction

  // one restoring step: shift in the next dividend bit, keep the difference if it is not negative
  function automatic logic [2*W:0] div_step(input logic [W:0] a, input logic [W-1:0] q,
                                            input logic [W-1:0] d);
    logic [W:0]   sh;
    logic [W+1:0] trial;
    logic         ok;
    sh    = {a[W-1:0], q[W-1]};
    trial = {1'b0, sh} - {2'b00, d};
    ok    = ~trial[W+1];
    return {(ok ? trial[W:0] : sh), q[W-2:0], ok};
  endfunction

  logic [2*W:0] res;

  always_comb begin
    if (is_div) res = div_step(acc, quo, opnd);
    else        res = mul_step(acc, quo, opnd);
  end

  assign acc_nx = res[2*W:W];
  assign quo_nx = res[W-1:0];
endmodule

// File: rtl/md_sign_fix.sv
`timescale 1ns/1ps
module md_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic             is_div,
  input  logic             neg_a,
  input  logic             neg_b,
  input  logic             div_zero,
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] lower,
  output logic [WIDTH-1:0] hi_res,
  output logic [WIDTH-1:0] lo_res
);
  localparam int W = WIDTH;

  function automatic logic [2*W-1:0] fix_product(input logic [2*W-1:0] p, input logic flip);
    return flip ? (~p + 1'b1) : p;
  endfunction

  function automatic logic [W-1:0] fix_word(input logic [W-1:0] v, input logic flip);
    return flip ? (~v + 1'b1) : v;
  endfunction

  logic [2*W-1:0] prod;

  always_comb begin
    prod = fix_product({upper, lower}, neg_a ^ neg_b);
    if (is_div) begin
      hi_res = fix_word(upper, neg_a);
      lo_res = fix_word(lower, (neg_a ^ neg_b) & ~div_zero);
    end else begin
      hi_res = prod[2*W-1:W];
      lo_res = prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
  import md_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             prod_fits
);
  localparam int            CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  // named events for the checker
  logic start_ok;
  logic last_iter;

  logic             busy_q, done_q, div_q, sgn_q, nega_q, negb_q, divz_q, res_signed_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH:0]   acc_q, acc_nx;
  logic [WIDTH-1:0] quo_q, quo_nx, opnd_q;
  logic [WIDTH-1:0] hi_q, lo_q, fix_hi, fix_lo;

  logic             op_signed;
  logic [WIDTH-1:0] raw [2];
  logic [WIDTH-1:0] mag [2];
  logic             neg [2];

  assign op_signed = op_is_signed(op);
  assign raw[0]    = opnd_a;
  assign raw[1]    = opnd_b;
  assign start_ok  = start & ~busy_q;
  assign last_iter = busy_q & (cnt_q == LAST);

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_mag
      md_magnitude #(.WIDTH(WIDTH)) u_mag (
        .value    (raw[gi]),
        .signed_en(op_signed),
        .mag      (mag[gi]),
        .neg      (neg[gi])
      );
    end
  endgenerate

  md_step #(.WIDTH(WIDTH)) u_step (
    .is_div(div_q),
    .acc   (acc_q),
    .quo   (quo_q),
    .opnd  (opnd_q),
    .acc_nx(acc_nx),
    .quo_nx(quo_nx)
  );

  md_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .is_div  (div_q),
    .neg_a   (nega_q),
    .neg_b   (negb_q),
    .div_zero(divz_q),
    .upper   (acc_nx[WIDTH-1:0]),
    .lower   (quo_nx),
    .hi_res  (fix_hi),
    .lo_res  (fix_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      div_q        <= 1'b0;
      sgn_q        <= 1'b0;
      nega_q       <= 1'b0;
      negb_q       <= 1'b0;
      divz_q       <= 1'b0;
      res_signed_q <= 1'b0;
      cnt_q        <= '0;
      acc_q        <= '0;
      quo_q        <= '0;
      opnd_q       <= '0;
      hi_q         <= '0;
      lo_q         <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        div_q  <= op_is_div(op);
        sgn_q  <= op_signed;
        nega_q <= neg[0];
        negb_q <= neg[1];
        divz_q <= (opnd_b == '0);
        acc_q  <= '0;
        if (op_is_div(op)) begin
          quo_q  <= mag[0];
          opnd_q <= mag[1];
        end else begin
          quo_q  <= mag[1];
          opnd_q <= mag[0];
        end
      end else if (busy_q) begin
        acc_q <= acc_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last_iter) begin
          busy_q       <= 1'b0;
          done_q       <= 1'b1;
          hi_q         <= fix_hi;
          lo_q         <= fix_lo;
          res_signed_q <= sgn_q;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign hi        = hi_q;
  assign lo        = lo_q;
  assign prod_fits = res_signed_q ? (hi_q == {WIDTH{lo_q[WIDTH-1]}}) : (hi_q == '0);
endmodule

// File: rtl/md_checker.sv
`timescale 1ns/1ps
module md_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_ok,
  input logic [1:0]       op,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);
  logic [1:0]       cap_op;
  logic [WIDTH-1:0] cap_a, cap_b;
  int unsigned      busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op   <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
      busy_len <= 0;
    end else begin
      if (start_ok) begin
        cap_op <= op;
        cap_a  <= opnd_a;
        cap_b  <= opnd_b;
      end
      if (busy) busy_len <= busy_len + 1;
      else      busy_len <= 0;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WIDTH); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R3
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hi) && $stable(lo)); // R4
  AST_MULU_MODEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == 2'b01) |->
      {hi, lo} == ({{WIDTH{1'b0}}, cap_a} * {{WIDTH{1'b0}}, cap_b})); // R6
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[1] && cap_b == '0) |-> (lo == '1) && (hi == cap_a)); // R10
endmodule

bind muldiv_hilo md_checker #(.WIDTH(WIDTH)) u_md_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_ok(start_ok),
  .op      (op),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .busy    (busy),
  .done    (done),
  .hi      (hi),
  .lo      (lo)
);

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
  import md_pkg::*;

  localparam int BW   = 4;
  localparam int MASK = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [BW-1:0] a = '0;
  logic [BW-1:0] b = '0;
  logic          busy, done, fits;
  logic [BW-1:0] hi, lo;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 4 ns period

  muldiv_hilo #(.WIDTH(BW)) i_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd_a(a), .opnd_b(b),
    .busy(busy), .done(done), .hi(hi), .lo(lo), .prod_fits(fits)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v & (1 << (BW - 1))) ? v - (1 << BW) : v;
  endfunction

  task automatic expect_res(input logic [1:0] o, input int ua, input int ub,
                            output int eh, output int el, output int ef);
    int p;
    int qq;
    int rr;
    case (o)
      OP_MULU: begin
        p = ua * ub;
        eh = (p >>> BW) & MASK; el = p & MASK; ef = (p <= MASK);
      end
      OP_MUL: begin
        p = sx(ua) * sx(ub);
        eh = (p >>> BW) & MASK; el = p & MASK;
        ef = (p >= -(1 << (BW - 1))) && (p < (1 << (BW - 1)));
      end
      default: begin
        if (ub == 0) begin
          el = MASK; eh = ua;
        end else begin
          if (o == OP_DIVU) begin qq = ua / ub; rr = ua % ub; end
          else begin qq = sx(ua) / sx(ub); rr = sx(ua) % sx(ub); end
          el = qq & MASK; eh = rr & MASK;
        end
        if (o == OP_DIVU) ef = (eh == 0);
        else ef = (eh == (((el >> (BW - 1)) & 1) ? MASK : 0));
      end
    endcase
  endtask

  task automatic run_op(input logic [1:0] o, input int ua, input int ub, input bit poke);
    int eh, el, ef, cyc;
    bit held;
    logic [BW-1:0] ph, pl;
    string tag;
    expect_res(o, ua, ub, eh, el, ef);
    if (o[1]) tag = (ub == 0) ? "R10" : (o[0] ? "R8" : "R9");
    else      tag = o[0] ? "R6" : "R7";
    if (poke) tag = {tag, " R5"};
    ph = hi; pl = lo;
    @(negedge clk);
    start = 1'b1; op = o; a = ua[BW-1:0]; b = ub[BW-1:0];
    @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", busy, 1);
    cyc = 0; held = 1'b1;
    while (busy && cyc < 100) begin
      if (poke && cyc == 1) begin
        start = 1'b1; op = ~o; a = a ^ 4'h5; b = b ^ 4'h3;
      end else begin
        start = 1'b0;
      end
      if (hi !== ph || lo !== pl || done) held = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check({"R3 busy length ", tag}, cyc, BW);
    check("R3 done strobe", done, 1);
    check("R4 hi/lo held while busy", held, 1);
    check({"R2 hi ", tag}, hi, eh);
    check({"R2 lo ", tag}, lo, el);
    check("R11 prod_fits", fits, ef);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 hi reset", hi, 0);
    check("R1 lo reset", lo, 0);
    check("R1 prod_fits reset", fits, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", busy, 0);
    for (int o = 0; o < 4; o++)
      for (int x = 0; x <= MASK; x++)
        for (int y = 0; y <= MASK; y++)
          run_op(o[1:0], x, y, 1'b0);
    // R5: strobes during busy must not disturb the running operation
    run_op(OP_MULU, 13, 11, 1'b1);
    run_op(OP_DIV, 8, 15, 1'b1);
    run_op(OP_DIVU, 9, 0, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule